// File: doc/BRIEF.md
# Iterative 160-bit Hash Compression Engine

This block applies a 160-bit hash compression function to one 512-bit message block. A caller presents the current chaining value and sixteen 32-bit message words, then pulses a start strobe. The engine loads the chaining value into five 32-bit working words and runs one round per clock for 80 rounds. Each round draws one expanded message word and one quarter-dependent constant. When the last round ends, the engine adds the original chaining value back word by word and reports the result with a one-cycle done pulse.

Multi-block hashing is left to the caller. Padding and length encoding are out of scope. For the next block, the caller feeds the returned digest back in as the new chaining value. Inputs are sampled only on the clock edge that accepts a start. A start that arrives while a block is still being processed is dropped.

Top module: `dig160_core`

## Requirements
- R1: While rst_n is low at a rising edge, the following cycle shows done_o = 0 and digest_o = 0.
- R2: A start accepted at rising edge E0 makes done_o high for exactly the one cycle that follows rising edge E0+80; done_o is low in every other cycle.
- R3: With chaining value 67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0 and a block whose word 0 is 61626380, whose word 15 is 00000018 and whose other words are zero, the digest is A9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D.
- R4: Rounds 0-19 use choose (x&y)|(~x&z) with constant 5A827999. Rounds 20-39 use parity x^y^z with 6ED9EBA1. Rounds 40-59 use majority with 8F1BBCDC. Rounds 60-79 use parity with CA62C1D6. Each round sets a' = e + rotl5(a) + f(b,c,d) + K + W, b' = a, c' = rotl30(b), d' = c and e' = d, with all sums mod 2^32.
- R5: Rounds 0-15 use message words 0-15 in order. Every later round t uses W = rotl1(W[t-3] ^ W[t-8] ^ W[t-14] ^ W[t-16]).
- R6: The digest is the final working words added mod 2^32 to the chaining value latched at start, word by word. Carries do not cross word boundaries.
- R7: A start that arrives while a block is in progress is ignored. The running block's digest and done timing are unchanged, and no extra done pulse follows.
- R8: chain_i and block_i are sampled only at the accepting edge. Changes to them during processing do not affect the result.
- R9: digest_o holds its value in every cycle in which done_o is low.
- R10: A start presented in the cycle in which done_o is high is accepted, so back-to-back blocks need no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a block when the engine is idle |
| chain_i | input | 160 | Chaining value; word a in bits 159:128, word e in bits 31:0 |
| block_i | input | 512 | Message block; word 0 in bits 511:480, word 15 in bits 31:0 |
| digest_o | output | 160 | Updated chaining value, same word layout as chain_i |
| done_o | output | 1 | One-cycle pulse when digest_o carries a new result |

## Verification
The only timed result is the digest together with its done pulse. Both become due 80 rising edges after the edge that accepts a start, and both are read in the cycle that follows that edge. The bench drives inputs on falling edges. A behavioural model advances on every rising edge and predicts done_o and digest_o, and the outputs are compared with the model at every falling edge. Start-to-done latency is also counted directly in falling edges, and the count must be exactly 81 (one falling edge after the accepting edge, plus 80 rounds).

// File: rtl/dig160_pkg.sv
// Package: shared word types, quarter selector and round helpers for the
// 160-bit compression engine. Assumes 32-bit words and a 16-word block.
package dig160_pkg;
    localparam int WORD_W      = 32;
    localparam int STATE_WORDS = 5;
    localparam int BLK_WORDS   = 16;
    localparam int STATE_W     = WORD_W * STATE_WORDS;
    localparam int BLK_W       = WORD_W * BLK_WORDS;
    localparam int TAP_NEAR    = 3;
    localparam int TAP_MID     = 8;
    localparam int TAP_FAR     = 14;
    localparam int ROT_A       = 5;
    localparam int ROT_B       = 30;

    typedef logic [WORD_W-1:0] word_t;

    // Working words, a in the most significant position.
    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } state_t;

    typedef enum logic [1:0] {
        PH_CHOOSE    = 2'd0,
        PH_PARITY_LO = 2'd1,
        PH_MAJORITY  = 2'd2,
        PH_PARITY_HI = 2'd3
    } phase_e;

    // Rotate a word left by a fixed amount.
    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // Additive constant of a quarter.
    function automatic word_t quarter_const(input phase_e p);
        case (p)
            PH_CHOOSE:    return 32'h5A82_7999;
            PH_PARITY_LO: return 32'h6ED9_EBA1;
            PH_MAJORITY:  return 32'h8F1B_BCDC;
            default:      return 32'hCA62_C1D6;
        endcase
    endfunction
endpackage

// File: rtl/dig160_seq.sv
// Round sequencer: accepts a start when idle, counts rounds, flags the
// last round, derives the quarter and registers the done pulse.
// Assumes ROUNDS is a multiple of four.
module dig160_seq
    import dig160_pkg::*;
#(
    parameter int ROUNDS = 80,
    localparam int RW    = $clog2(ROUNDS),
    localparam int QTR   = ROUNDS / 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          busy,
    output logic [RW-1:0] rnd,
    output logic          load,
    output logic          last,
    output phase_e        phase,
    output logic          done_o
);
    // Accept only while idle; flag the final round.
    always_comb begin
        load = start_i & ~busy;
        last = busy & (rnd == RW'(ROUNDS - 1));
    end

    // Quarter selection from the round index.
    always_comb begin
        if (rnd < RW'(QTR))
            phase = PH_CHOOSE;
        else if (rnd < RW'(2 * QTR))
            phase = PH_PARITY_LO;
        else if (rnd < RW'(3 * QTR))
            phase = PH_MAJORITY;
        else
            phase = PH_PARITY_HI;
    end

    // Busy flag, round counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            rnd    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= last;
            if (load) begin
                busy <= 1'b1;
                rnd  <= '0;
            end else if (last) begin
                busy <= 1'b0;
                rnd  <= '0;
            end else if (busy) begin
                rnd <= rnd + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dig160_sched.sv
// Message schedule: a 16-slot circular store loaded with the block. The
// first 16 rounds read slots in order; later rounds read the expansion,
// which overwrites the slot holding W[t-16]. Assumes a power-of-two slot count.
module dig160_sched
    import dig160_pkg::*;
#(
    parameter int ROUNDS = 80,
    localparam int RW    = $clog2(ROUNDS),
    localparam int SW    = $clog2(BLK_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [BLK_W-1:0] block_i,
    input  logic [RW-1:0]    rnd,
    output word_t            w_cur
);
    word_t          blk_w  [BLK_WORDS];
    word_t          slot_q [BLK_WORDS];
    logic [SW-1:0]  cur_i, near_i, mid_i, far_i;
    logic           early;
    word_t          expanded;

    // Unpack the block, word 0 at the top.
    for (genvar gi = 0; gi < BLK_WORDS; gi++) begin : g_unpack
        assign blk_w[gi] = block_i[BLK_W - 1 - gi*WORD_W -: WORD_W];
    end

    // Slot addresses of the four taps relative to the current round.
    always_comb begin
        cur_i  = rnd[SW-1:0];
        near_i = cur_i - SW'(TAP_NEAR);
        mid_i  = cur_i - SW'(TAP_MID);
        far_i  = cur_i - SW'(TAP_FAR);
        early  = (rnd < RW'(BLK_WORDS));
    end

    // Expansion and selection of this round's word.
    always_comb begin
        expanded = rotl(slot_q[near_i] ^ slot_q[mid_i] ^ slot_q[far_i] ^ slot_q[cur_i], 1);
        w_cur    = early ? slot_q[cur_i] : expanded;
    end

    // Slot store: bulk load on start, one write-back per late round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BLK_WORDS; i++) slot_q[i] <= '0;
        end else if (load) begin
            for (int i = 0; i < BLK_WORDS; i++) slot_q[i] <= blk_w[i];
        end else if (step && !early) begin
            slot_q[cur_i] <= expanded;
        end
    end
endmodule

// File: rtl/dig160_round.sv
// One compression round, purely combinational: quarter function of b,c,d,
// five-term modular sum into a, fixed rotation of b, renaming of the rest.
module dig160_round
    import dig160_pkg::*;
(
    input  state_t cur,
    input  word_t  w,
    input  phase_e phase,
    output state_t nxt
);
    word_t mix;

    // Quarter-dependent bitwise function.
    always_comb begin
        case (phase)
            PH_CHOOSE:   mix = (cur.b & cur.c) | (~cur.b & cur.d);
            PH_MAJORITY: mix = (cur.b & cur.c) | (cur.b & cur.d) | (cur.c & cur.d);
            default:     mix = cur.b ^ cur.c ^ cur.d;
        endcase
    end

    // New working words.
    always_comb begin
        nxt.a = cur.e + rotl(cur.a, ROT_A) + mix + quarter_const(phase) + w;
        nxt.b = cur.a;
        nxt.c = rotl(cur.b, ROT_B);
        nxt.d = cur.c;
        nxt.e = cur.d;
    end
endmodule

// File: rtl/dig160_core.sv
// Top: iterative 160-bit compression, one round per clock. Latches the
// chaining value at start, runs ROUNDS rounds, then adds the latched value
// to the final working words and pulses done. Starts while busy are dropped.
module dig160_core
    import dig160_pkg::*;
#(
    parameter int ROUNDS = 80,
    localparam int RW    = $clog2(ROUNDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [STATE_W-1:0] chain_i,
    input  logic [BLK_W-1:0]   block_i,
    output logic [STATE_W-1:0] digest_o,
    output logic               done_o
);
    logic          busy, load, last;
    logic [RW-1:0] rnd;
    phase_e        phase;
    word_t         w_cur;
    state_t        st_q, st_nxt, chain_q;
    logic [STATE_W-1:0] sum_v;

    dig160_seq #(.ROUNDS(ROUNDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .busy(busy), .rnd(rnd), .load(load), .last(last),
        .phase(phase), .done_o(done_o)
    );

    dig160_sched #(.ROUNDS(ROUNDS)) u_sched (
        .clk(clk), .rst_n(rst_n), .load(load), .step(busy),
        .block_i(block_i), .rnd(rnd), .w_cur(w_cur)
    );

    dig160_round u_round (
        .cur(st_q), .w(w_cur), .phase(phase), .nxt(st_nxt)
    );

    // Per-word chaining addition, no carry between words.
    for (genvar gi = 0; gi < STATE_WORDS; gi++) begin : g_fold
        assign sum_v[gi*WORD_W +: WORD_W] =
            chain_q[gi*WORD_W +: WORD_W] + st_nxt[gi*WORD_W +: WORD_W];
    end

    // Working words and latched chaining value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            chain_q <= '0;
        end else if (load) begin
            st_q    <= chain_i;
            chain_q <= chain_i;
        end else if (busy) begin
            st_q <= st_nxt;
        end
    end

    // Result register, updated only after the final round.
    always_ff @(posedge clk) begin
        if (!rst_n)
            digest_o <= '0;
        else if (last)
            digest_o <= sum_v;
    end
endmodule

// File: rtl/dig160_chk.sv
// Checker for dig160_core: protocol and timing properties, bound to the top.
module dig160_chk #(
    parameter int ROUNDS = 80,
    localparam int RW    = $clog2(ROUNDS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          done_o,
    input logic [159:0]  digest_o,
    input logic          busy,
    input logic [RW-1:0] rnd
);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    done_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rnd == RW'(ROUNDS - 1)) |=> (done_o && !busy));

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i && rnd != RW'(ROUNDS - 1)) |=> (busy && rnd == RW'($past(rnd) + 1'b1)));

    // R9
    digest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(digest_o));

    // R10
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_i) |=> (busy && rnd == '0));
endmodule

bind dig160_core dig160_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .digest_o(digest_o), .busy(busy), .rnd(rnd)
);

// File: tb/sim_dig160_core.sv
module sim_dig160_core;
    localparam int CLK_PERIOD = 10;
    localparam int ROUNDS     = 80;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [159:0] chain_i = '0;
    logic [511:0] block_i = '0;
    logic [159:0] digest_o;
    logic         done_o;

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";

    dig160_core #(.ROUNDS(ROUNDS)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chain_i(chain_i),
        .block_i(block_i), .digest_o(digest_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural compression reference.
    function automatic logic [159:0] ref_compress(input logic [159:0] cv, input logic [511:0] blk);
        int unsigned w[80];
        int unsigned h[5];
        int unsigned a, b, c, d, e, f, k, tmp;
        for (int t = 0; t < 16; t++) w[t] = blk[511 - 32*t -: 32];
        for (int t = 16; t < 80; t++) begin
            tmp  = w[t-3] ^ w[t-8] ^ w[t-14] ^ w[t-16];
            w[t] = (tmp << 1) | (tmp >> 31);
        end
        for (int i = 0; i < 5; i++) h[i] = cv[159 - 32*i -: 32];
        a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4];
        for (int t = 0; t < 80; t++) begin
            if (t < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            else if (t < 40) begin f = b ^ c ^ d;                    k = 32'h6ED9EBA1; end
            else if (t < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                    k = 32'hCA62C1D6; end
            tmp = ((a << 5) | (a >> 27)) + f + e + k + w[t];
            e = d; d = c; c = (b << 30) | (b >> 2); b = a; a = tmp;
        end
        return {h[0] + a, h[1] + b, h[2] + c, h[3] + d, h[4] + e};
    endfunction

    // Cycle model: predicts done and digest after every rising edge.
    bit           m_busy = 0;
    int           m_cnt = 0;
    logic [159:0] m_res = '0;
    logic         exp_done = 0;
    logic [159:0] exp_dig = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; exp_done = 0; exp_dig = '0;
        end else begin
            exp_done = 0;
            if (m_busy) begin
                if (m_cnt == ROUNDS - 1) begin
                    exp_done = 1; exp_dig = m_res; m_busy = 0;
                end else begin
                    m_cnt++;
                end
            end else if (start_i) begin
                m_busy = 1; m_cnt = 0; m_res = ref_compress(chain_i, block_i);
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(done_o == exp_done, {cur_req, " done"}, 160'(done_o), 160'(exp_done));
            check(digest_o == exp_dig, {cur_req, " digest"}, digest_o, exp_dig);
        end
    end

    task automatic drive_start(input logic [159:0] cv, input logic [511:0] blk);
        chain_i = cv; block_i = blk; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic launch(input logic [159:0] cv, input logic [511:0] blk);
        @(negedge clk);
        drive_start(cv, blk);
    endtask

    // Counts falling edges from the one after the accepting edge to done.
    task automatic wait_done(output int lat);
        lat = 1;
        while (!done_o && lat < 300) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic logic [511:0] rand_block();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [159:0] rand_chain();
        logic [159:0] r;
        for (int i = 0; i < 5; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    localparam logic [159:0] IV = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int           lat;
        logic [159:0] cv_a, cv_b, held;
        logic [511:0] blk_a, blk_b;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(done_o == 1'b0, "R1", 160'(done_o), 160'd0);
        check(digest_o == '0, "R1", digest_o, 160'd0);
        rst_n = 1'b1;

        // R3: known vector, R2: latency
        cur_req = "R3";
        blk_a = '0; blk_a[511:480] = 32'h61626380; blk_a[31:0] = 32'h00000018;
        launch(IV, blk_a);
        wait_done(lat);
        check(lat == 81, "R2 latency", 160'(lat), 160'd81);
        check(digest_o == 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D, "R3",
              digest_o, 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);

        // R6: all-ones chain and block, heavy carry wrap in every word
        cur_req = "R6";
        launch({160{1'b1}}, {512{1'b1}});
        wait_done(lat);
        check(digest_o == ref_compress({160{1'b1}}, {512{1'b1}}), "R6", digest_o,
              ref_compress({160{1'b1}}, {512{1'b1}}));

        // R5: only the last word set, so late rounds depend on expansion
        cur_req = "R5";
        blk_a = '0; blk_a[31:0] = 32'h8000_0001;
        launch('0, blk_a);
        wait_done(lat);
        check(digest_o == ref_compress('0, blk_a), "R5", digest_o, ref_compress('0, blk_a));

        // R4: random chains and blocks over all four quarters
        cur_req = "R4";
        for (int n = 0; n < 6; n++) begin
            cv_a = rand_chain(); blk_a = rand_block();
            launch(cv_a, blk_a);
            wait_done(lat);
            check(digest_o == ref_compress(cv_a, blk_a), "R4", digest_o, ref_compress(cv_a, blk_a));
        end

        // R9: result holds while idle
        cur_req = "R9";
        held = digest_o;
        repeat (30) @(negedge clk);
        check(digest_o == held, "R9", digest_o, held);

        // R7: second start during processing is dropped
        cur_req = "R7";
        cv_a = rand_chain(); blk_a = rand_block();
        cv_b = rand_chain(); blk_b = rand_block();
        launch(cv_a, blk_a);
        repeat (10) @(negedge clk);
        drive_start(cv_b, blk_b);
        wait_done(lat);
        check(lat == 81 - 11, "R7 timing", 160'(lat), 160'd70);
        check(digest_o == ref_compress(cv_a, blk_a), "R7", digest_o, ref_compress(cv_a, blk_a));
        lat = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (done_o) lat++;
        end
        check(lat == 0, "R7 extra done", 160'(lat), 160'd0);

        // R8: inputs changed mid-block have no effect
        cur_req = "R8";
        cv_a = rand_chain(); blk_a = rand_block();
        launch(cv_a, blk_a);
        repeat (5) @(negedge clk);
        chain_i = rand_chain(); block_i = rand_block();
        wait_done(lat);
        check(digest_o == ref_compress(cv_a, blk_a), "R8", digest_o, ref_compress(cv_a, blk_a));

        // R10: back-to-back start in the done cycle
        cur_req = "R10";
        cv_a = rand_chain(); blk_a = rand_block();
        cv_b = rand_chain(); blk_b = rand_block();
        launch(cv_a, blk_a);
        wait_done(lat);
        drive_start(cv_b, blk_b);
        wait_done(lat);
        check(lat == 81, "R10 latency", 160'(lat), 160'd81);
        check(digest_o == ref_compress(cv_b, blk_b), "R10", digest_o, ref_compress(cv_b, blk_b));

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule